// File: doc/BRIEF.md
# Codec Control Register Target

This block is the control plane of a voice codec. It is an I2C target clocked by the system clock: it oversamples the bus, holds six 8-bit control registers and drives their fields to the rest of the datapath. These fields are the power enable, the sidetone enable, the mode bits, the transmit gain, the sidetone attenuation, the receive gain, the receive volume and two tone codes. The SDA line is open-drain. The block only pulls it low, and only to acknowledge a byte or to return a zero read bit.

A strap input is sampled by reset and picks one of two start states. In the first, the codec comes up enabled with sidetone on and every gain at its neutral code, so no host is needed. In the second, the codec comes up powered down and waits for a host write to the power register. A host writes a pointer byte and then any number of data bytes, which auto-increment the pointer. It reads back through a repeated start.

Top module: `codec_ctrl_regs`

## Requirements
- R1: With `boot_active` high during reset, register 0 resets to 0x03, so `dev_on` and `sidetone_on` are 1. Registers 1 to 5 reset to 0x00, which gives transmit gain code 0 (0 dB), sidetone code 0 (-12 dB) and volume code 0 (0 dB).
- R2: With `boot_active` low during reset, register 0 resets to 0x00 and `dev_on` stays 0. It rises only after a host write of a value with bit 0 set to register 0.
- R3: The target responds to the 7-bit address `DEV_ADDR` (default 0x48, R/W bit 0 = write). It acknowledges the address byte and every written byte by holding SDA low during the ninth clock. In a write, the first byte after the address loads the register pointer.
- R4: Each data byte after the pointer byte is stored in the register the pointer selects, and the pointer then increments by one.
- R5: A data byte written while the pointer is above 5 is acknowledged but changes no register. A read at such a pointer returns 0x00.
- R6: A read (R/W bit 1) returns the register at the pointer, MSB first. After each byte, the host ACK advances the pointer and a further byte follows. A host NACK ends the transfer.
- R7: An address byte with any other address gets no acknowledge, and the following bytes change nothing.
- R8: The target changes its SDA drive only while SCL is low.
- R9: The field map is fixed. `dev_on` = reg0[0] and `sidetone_on` = reg0[1]. `mode_bits` = reg1. `tx_gain` = reg2[3:0] and `side_att` = reg2[7:4]. `rx_pga` = reg3[3:0] and `rx_vol` = reg3[7:4]. `tone_hi` = reg4 and `tone_lo` = reg5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_active | input | 1 | Strap: 1 = start enabled with defaults, 0 = start powered down |
| scl_in | input | 1 | I2C clock line |
| sda_in | input | 1 | I2C data line as seen on the pad |
| sda_oe | output | 1 | 1 = pull SDA low |
| dev_on | output | 1 | Codec power enable |
| sidetone_on | output | 1 | Sidetone path enable |
| mode_bits | output | 8 | Mode control register |
| tx_gain | output | 4 | Transmit gain code |
| side_att | output | 4 | Sidetone attenuation code |
| rx_pga | output | 4 | Receive gain code |
| rx_vol | output | 4 | Receive volume attenuation code |
| tone_hi | output | 8 | High tone code |
| tone_lo | output | 8 | Low tone code |

## Verification
Three properties are checked on every clock:
- SDA drive changes only while SCL is low.
- A register write strobe comes only out of a data-byte phase.
- The register contents hold still unless an in-range write arrives.

The bench scenarios cover what needs whole transactions:
- both strap start states;
- acknowledgement and its absence for a foreign address;
- pointer auto-increment across a burst;
- discarded writes above index 5;
- sequential read-back ended by a NACK.

// File: rtl/codec_ctrl_pkg.sv
package codec_ctrl_pkg;

    localparam int REG_W    = 8;
    localparam int PTR_W    = 8;
    localparam int NUM_REGS = 6;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int GAIN_W   = 4;

    localparam int IDX_PWR  = 0;
    localparam int IDX_MODE = 1;
    localparam int IDX_TX   = 2;
    localparam int IDX_RX   = 3;
    localparam int IDX_THI  = 4;
    localparam int IDX_TLO  = 5;

    localparam int PWR_EN_BIT   = 0;
    localparam int PWR_SIDE_BIT = 1;

    localparam logic [REG_W-1:0] PWR_BOOT_ON  = 8'h03;
    localparam logic [REG_W-1:0] PWR_BOOT_OFF = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } bus_state_e;

    typedef struct packed {
        bus_state_e         state;
        logic [3:0]         cnt;
        logic [REG_W-1:0]   shreg;
        logic [PTR_W-1:0]   ptr;
        logic               first;
        logic               rw;
        logic               ack_ok;
        logic               sda_oe;
        logic               wr_en;
        logic [PTR_W-1:0]   wr_idx;
        logic [REG_W-1:0]   wr_data;
    } bus_regs_t;

    function automatic logic [REG_W-1:0] reset_value(input int idx, input logic boot);
        if (idx == IDX_PWR) return boot ? PWR_BOOT_ON : PWR_BOOT_OFF;
        return '0;
    endfunction

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= 1'b1;
                else if (g == 0) chain_q[g] <= pin;
                else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign lvl  = chain_q[STAGES-1];
    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import codec_ctrl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [REG_W-1:0]  rd_data,
    output logic [PTR_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_idx,
    output logic [REG_W-1:0]  wr_data,
    output logic              sda_oe
);
    localparam bus_regs_t RESET_ST = '{state: ST_IDLE, default: '0};

    bus_regs_t q, d;
    logic start_c, stop_c;

    assign start_c = sda_fall & scl_lvl;
    assign stop_c  = sda_rise & scl_lvl;

    always_comb begin
        d = q;
        d.wr_en = 1'b0;
        if (start_c) begin
            d.state  = ST_ADDR;
            d.cnt    = '0;
            d.first  = 1'b1;
            d.sda_oe = 1'b0;
        end else if (stop_c) begin
            d.state  = ST_IDLE;
            d.sda_oe = 1'b0;
        end else begin
            case (q.state)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        d.shreg = {q.shreg[REG_W-2:0], sda_lvl};
                        d.cnt   = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        if (q.state == ST_ADDR) begin
                            if (q.shreg[7:1] == DEV_ADDR) begin
                                d.state  = ST_ADDR_ACK;
                                d.rw     = q.shreg[0];
                                d.sda_oe = 1'b1;
                            end else begin
                                d.state  = ST_IDLE;
                            end
                        end else begin
                            d.state  = ST_WACK;
                            d.sda_oe = 1'b1;
                            if (q.first) begin
                                d.ptr   = q.shreg;
                                d.first = 1'b0;
                            end else begin
                                d.wr_en   = 1'b1;
                                d.wr_idx  = q.ptr;
                                d.wr_data = q.shreg;
                                d.ptr     = q.ptr + 1'b1;
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.state  = ST_RDATA;
                            d.shreg  = rd_data;
                            d.sda_oe = ~rd_data[REG_W-1];
                        end else begin
                            d.state  = ST_WDATA;
                            d.sda_oe = 1'b0;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        d.state  = ST_WDATA;
                        d.cnt    = '0;
                        d.sda_oe = 1'b0;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.state  = ST_RACK;
                            d.sda_oe = 1'b0;
                        end else begin
                            d.shreg  = {q.shreg[REG_W-2:0], 1'b0};
                            d.sda_oe = ~q.shreg[REG_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.ack_ok = ~sda_lvl;
                        if (!sda_lvl) d.ptr = q.ptr + 1'b1;
                    end else if (scl_fall) begin
                        if (q.ack_ok) begin
                            d.state  = ST_RDATA;
                            d.shreg  = rd_data;
                            d.sda_oe = ~rd_data[REG_W-1];
                            d.cnt    = '0;
                        end else begin
                            d.state  = ST_IDLE;
                        end
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_ST;
        else        q <= d;
    end

    assign rd_idx  = q.ptr;
    assign wr_en   = q.wr_en;
    assign wr_idx  = q.wr_idx;
    assign wr_data = q.wr_data;
    assign sda_oe  = q.sda_oe;

    // R8
    sda_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sda_oe != $past(q.sda_oe)) |-> !scl_lvl);

    // R4
    write_from_data_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |-> $past(q.state == ST_WDATA));
endmodule

// File: rtl/ctrl_regfile.sv
module ctrl_regfile
    import codec_ctrl_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            boot_active,
    input  logic                            wr_en,
    input  logic [PTR_W-1:0]                wr_idx,
    input  logic [REG_W-1:0]                wr_data,
    input  logic [PTR_W-1:0]                rd_idx,
    output logic [REG_W-1:0]                rd_data,
    output logic [NUM_REGS-1:0][REG_W-1:0]  regs
);
    localparam logic [PTR_W-1:0] LIMIT = PTR_W'(NUM_REGS);

    logic [NUM_REGS-1:0][REG_W-1:0] regs_q, regs_d;

    always_comb begin
        regs_d = regs_q;
        if (wr_en && wr_idx < LIMIT) regs_d[wr_idx[IDX_W-1:0]] = wr_data;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) regs_q[g] <= reset_value(g, boot_active);
                else        regs_q[g] <= regs_d[g];
            end
        end
    endgenerate

    assign rd_data = (rd_idx < LIMIT) ? regs_q[rd_idx[IDX_W-1:0]] : '0;
    assign regs    = regs_q;

    // R5
    high_index_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= LIMIT) |=> $stable(regs_q));

    // R2
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));
endmodule

// File: rtl/codec_ctrl_regs.sv
module codec_ctrl_regs
    import codec_ctrl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h48,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_active,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic              dev_on,
    output logic              sidetone_on,
    output logic [REG_W-1:0]  mode_bits,
    output logic [GAIN_W-1:0] tx_gain,
    output logic [GAIN_W-1:0] side_att,
    output logic [GAIN_W-1:0] rx_pga,
    output logic [GAIN_W-1:0] rx_vol,
    output logic [REG_W-1:0]  tone_hi,
    output logic [REG_W-1:0]  tone_lo
);
    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic wr_en;
    logic [PTR_W-1:0] wr_idx, rd_idx;
    logic [REG_W-1:0] wr_data, rd_data;
    logic [NUM_REGS-1:0][REG_W-1:0] regs;

    i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst_n(rst_n), .pin(scl_in),
        .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall));

    i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst_n(rst_n), .pin(sda_in),
        .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall));

    i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .rd_data(rd_data), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sda_oe(sda_oe));

    ctrl_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .boot_active(boot_active),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .regs(regs));

    assign dev_on      = regs[IDX_PWR][PWR_EN_BIT];
    assign sidetone_on = regs[IDX_PWR][PWR_SIDE_BIT];
    assign mode_bits   = regs[IDX_MODE];
    assign tx_gain     = regs[IDX_TX][GAIN_W-1:0];
    assign side_att    = regs[IDX_TX][REG_W-1:GAIN_W];
    assign rx_pga      = regs[IDX_RX][GAIN_W-1:0];
    assign rx_vol      = regs[IDX_RX][REG_W-1:GAIN_W];
    assign tone_hi     = regs[IDX_THI];
    assign tone_lo     = regs[IDX_TLO];
endmodule

// File: tb/codec_ctrl_regs_test.sv
module codec_ctrl_regs_test;
    localparam int HALF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boot_active = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, dev_on, sidetone_on;
    logic [7:0] mode_bits, tone_hi, tone_lo;
    logic [3:0] tx_gain, side_att, rx_pga, rx_vol;
    wire sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_val[$];
    string      exp_req[$];
    logic [7:0] obs_val[$];

    always #4 clk = ~clk;

    codec_ctrl_regs uut (
        .clk(clk), .rst_n(rst_n), .boot_active(boot_active),
        .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
        .dev_on(dev_on), .sidetone_on(sidetone_on), .mode_bits(mode_bits),
        .tx_gain(tx_gain), .side_att(side_att), .rx_pga(rx_pga), .rx_vol(rx_vol),
        .tone_hi(tone_hi), .tone_lo(tone_lo));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_item(input logic [7:0] v, input string req);
        exp_val.push_back(v);
        exp_req.push_back(req);
    endtask

    initial begin : monitor
        forever begin
            wait (obs_val.size() != 0);
            begin
                logic [7:0] o;
                o = obs_val.pop_front();
                if (exp_val.size() == 0) check("scoreboard", {24'd0, o}, 32'hFFFF);
                else check(exp_req.pop_front(), {24'd0, o}, {24'd0, exp_val.pop_front()});
            end
        end
    end

    task automatic hp();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
        end
        sda_m = 1'b1; hp(); scl_m = 1'b1; hp();
        obs_val.push_back({7'd0, ~sda_bus});
        scl_m = 1'b0; hp();
    endtask

    task automatic recv_byte(input logic host_ack);
        logic [7:0] b;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hp(); scl_m = 1'b1; hp(); b[i] = sda_bus; scl_m = 1'b0;
        end
        obs_val.push_back(b);
        sda_m = ~host_ack; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; hp(); sda_m = 1'b1;
    endtask

    task automatic do_reset(input logic strap);
        boot_active = strap;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic drain();
        wait (obs_val.size() == 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        // R1: boot into enabled defaults
        do_reset(1'b1);
        check("R1 dev_on", {31'd0, dev_on}, 32'd1);
        check("R1 sidetone_on", {31'd0, sidetone_on}, 32'd1);
        check("R1 tx_gain 0dB", {28'd0, tx_gain}, 32'd0);
        check("R1 side_att -12dB", {28'd0, side_att}, 32'd0);
        check("R1 rx_vol 0dB", {28'd0, rx_vol}, 32'd0);
        check("R1 sda released", {31'd0, sda_oe}, 32'd0);

        // R6: read register 0 back
        bus_start();
        expect_item(8'd1, "R3 addr ack"); send_byte(8'h90);
        expect_item(8'd1, "R3 ptr ack");  send_byte(8'h00);
        bus_start();
        expect_item(8'd1, "R6 read addr ack"); send_byte(8'h91);
        expect_item(8'h03, "R6 read reg0 boot"); recv_byte(1'b0);
        bus_stop();
        drain();

        // R7: foreign address
        bus_start();
        expect_item(8'd0, "R7 no ack"); send_byte(8'h92);
        expect_item(8'd0, "R7 no ack data"); send_byte(8'h00);
        expect_item(8'd0, "R7 no ack data2"); send_byte(8'h00);
        bus_stop();
        drain();
        check("R7 dev_on unchanged", {31'd0, dev_on}, 32'd1);

        // R2: boot powered down
        do_reset(1'b0);
        check("R2 dev_on off", {31'd0, dev_on}, 32'd0);
        check("R2 sidetone off", {31'd0, sidetone_on}, 32'd0);
        repeat (200) @(negedge clk);
        check("R2 stays off", {31'd0, dev_on}, 32'd0);
        bus_start();
        expect_item(8'd1, "R3 addr ack"); send_byte(8'h90);
        expect_item(8'd1, "R3 ptr ack");  send_byte(8'h00);
        expect_item(8'd1, "R3 data ack"); send_byte(8'h01);
        bus_stop();
        drain();
        check("R2 dev_on after write", {31'd0, dev_on}, 32'd1);
        check("R2 sidetone still off", {31'd0, sidetone_on}, 32'd0);

        // R4 / R9: burst from index 2
        bus_start();
        expect_item(8'd1, "R4 addr ack"); send_byte(8'h90);
        expect_item(8'd1, "R4 ptr ack");  send_byte(8'h02);
        expect_item(8'd1, "R4 ack"); send_byte(8'hA5);
        expect_item(8'd1, "R4 ack"); send_byte(8'h3C);
        expect_item(8'd1, "R4 ack"); send_byte(8'h5E);
        expect_item(8'd1, "R4 ack"); send_byte(8'h81);
        bus_stop();
        drain();
        check("R9 tx_gain", {28'd0, tx_gain}, 32'h5);
        check("R9 side_att", {28'd0, side_att}, 32'hA);
        check("R9 rx_pga", {28'd0, rx_pga}, 32'hC);
        check("R9 rx_vol", {28'd0, rx_vol}, 32'h3);
        check("R9 tone_hi", {24'd0, tone_hi}, 32'h5E);
        check("R9 tone_lo", {24'd0, tone_lo}, 32'h81);
        check("R9 mode_bits", {24'd0, mode_bits}, 32'h00);

        // R5: crossing past index 5 and a direct high-index write
        bus_start();
        expect_item(8'd1, "R5 addr ack"); send_byte(8'h90);
        expect_item(8'd1, "R5 ptr ack");  send_byte(8'h05);
        expect_item(8'd1, "R5 ack idx5"); send_byte(8'h11);
        expect_item(8'd1, "R5 ack idx6"); send_byte(8'h99);
        bus_stop();
        bus_start();
        expect_item(8'd1, "R5 addr ack"); send_byte(8'h90);
        expect_item(8'd1, "R5 ptr ack");  send_byte(8'h07);
        expect_item(8'd1, "R5 ack idx7"); send_byte(8'h77);
        bus_stop();
        drain();
        check("R5 tone_lo", {24'd0, tone_lo}, 32'h11);
        check("R5 tone_hi kept", {24'd0, tone_hi}, 32'h5E);
        check("R5 dev_on kept", {31'd0, dev_on}, 32'd1);

        // R6: sequential read of every register, then index 6
        bus_start();
        expect_item(8'd1, "R6 addr ack"); send_byte(8'h90);
        expect_item(8'd1, "R6 ptr ack");  send_byte(8'h00);
        bus_start();
        expect_item(8'd1, "R6 read addr ack"); send_byte(8'h91);
        expect_item(8'h01, "R6 reg0"); recv_byte(1'b1);
        expect_item(8'h00, "R6 reg1"); recv_byte(1'b1);
        expect_item(8'hA5, "R6 reg2"); recv_byte(1'b1);
        expect_item(8'h3C, "R6 reg3"); recv_byte(1'b1);
        expect_item(8'h5E, "R6 reg4"); recv_byte(1'b1);
        expect_item(8'h11, "R6 reg5"); recv_byte(1'b1);
        expect_item(8'h00, "R5 read idx6 zero"); recv_byte(1'b0);
        bus_stop();
        drain();
        check("R8 sda released after NACK", {31'd0, sda_oe}, 32'd0);
        check("R6 scoreboard empty", exp_val.size(), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule